// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular window of in-flight instructions. At issue, each instruction claims the next free slot and gets back a tag naming that slot. Execution units then report results by tag in whatever order they finish. The block retires those results to the architectural register file one at a time, always from the oldest slot. This keeps register updates in program order, even when several in-flight instructions target the same register.

A result can carry a fault flag or a wrong-path branch flag. Nothing happens when the result arrives. When that slot becomes the oldest, the block emits a one-cycle flush pulse with a cause code and empties the whole window behind it. The next tag handed out is then the slot just after the offending one. A faulting instruction never writes its register. A wrong-path branch still performs its own register write (a link value, for example), because its own result is valid.

Top module: `reorder_buffer`

## Requirements
- R1: After synchronous reset the window is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `commit_we` and `flush_o` are 0.
- R2: An allocation is accepted when `alloc_req` and `alloc_ready` are both high at a rising edge. Accepted allocations receive tags 0,1,...,7,0,... in order of acceptance, and `alloc_tag` shows the tag the next accepted allocation will receive.
- R3: Results may arrive in any order. Slots retire strictly in allocation order, at most one per cycle, and only once the oldest slot has its result.
- R4: A retiring slot drives `commit_we` high only if it was allocated with `alloc_wr_en` set and carries no fault. In that case `commit_reg` and `commit_data` equal its destination and written value.
- R5: With 8 slots outstanding, `alloc_ready` is 0 and a request does not claim a tag.
- R6: An allocation and a retirement can complete in the same cycle.
- R7: A faulting oldest slot retires without a register write and raises `flush_o` for one cycle with `flush_cause` = 1. All younger slots are discarded, and the next tag is the faulting tag plus one.
- R8: A wrong-path branch at the oldest slot performs its own register write if enabled and raises `flush_o` with `flush_cause` = 2. All younger slots are discarded, and the next tag is its tag plus one.
- R9: A result write to a slot that holds no instruction has no effect. A later allocation of that slot still waits for its own result.
- R10: If a result carries both flags, the fault wins: `flush_cause` = 1 and there is no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request a slot for a new instruction |
| alloc_wr_en | input | 1 | Instruction writes a destination register |
| alloc_dest | input | 5 | Destination register number |
| alloc_ready | output | 1 | A request this cycle will be accepted |
| alloc_tag | output | 3 | Tag given to the next accepted request |
| res_valid | input | 1 | A result is being delivered |
| res_tag | input | 3 | Slot the result belongs to |
| res_data | input | 32 | Result value |
| res_fault | input | 1 | Instruction raised an exception |
| res_redirect | input | 1 | Branch turned out mispredicted |
| commit_we | output | 1 | Register file write enable |
| commit_reg | output | 5 | Register file write address |
| commit_data | output | 32 | Register file write data |
| flush_o | output | 1 | One-cycle pulse: younger slots discarded |
| flush_cause | output | 2 | 0 none, 1 exception, 2 mispredict |

## Verification
The assertions rely on the environment in three ways. Requests are sampled only when `alloc_ready` is high. Reset is held for a few cycles before traffic starts. Each live slot receives at most one result. The stimulus follows these rules: every request is issued only after the bench has seen `alloc_ready` high, each allocated tag is completed exactly once, and stale writes go only to slots the bench knows to be empty. Commits and flushes are compared in order against a queue of expected events filled by the stimulus tasks.

// File: rtl/rob_pkg.sv
package rob_pkg;
    parameter int ROB_DEPTH = 8;
    parameter int REG_W     = 5;
    parameter int DATA_W    = 32;

    localparam int TAG_W = $clog2(ROB_DEPTH);
    localparam int CNT_W = TAG_W + 1;

    typedef logic [TAG_W-1:0] tag_t;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_EXC     = 2'd1,
        CAUSE_MISPRED = 2'd2
    } flush_cause_e;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              fault;
        logic              redirect;
        logic              wr_en;
        logic [REG_W-1:0]  dest;
        logic [DATA_W-1:0] value;
    } rob_entry_t;

    function automatic tag_t tag_next(input tag_t t);
        return (t == tag_t'(ROB_DEPTH - 1)) ? '0 : t + 1'b1;
    endfunction
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl
    import rob_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic alloc_fire,
    input  logic retire,
    input  logic flush,
    output tag_t head,
    output tag_t tail,
    output logic full
);
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (flush) begin
            head  <= tag_next(head);
            tail  <= tag_next(head);
            count <= '0;
        end else begin
            if (retire)     head <= tag_next(head);
            if (alloc_fire) tail <= tag_next(tail);
            count <= count + CNT_W'(alloc_fire) - CNT_W'(retire);
        end
    end

    assign full = (count == CNT_W'(ROB_DEPTH));

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(ROB_DEPTH));

    // R3
    empty_no_retire_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !retire);

    // R3
    head_step_chk: assert property (@(posedge clk) disable iff (rst)
        (retire && !flush) |=> head == tag_next($past(head)));

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> count == '0);
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array
    import rob_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_fire,
    input  tag_t              tail,
    input  logic              alloc_wr_en,
    input  logic [REG_W-1:0]  alloc_dest,
    input  logic              res_valid,
    input  tag_t              res_tag,
    input  logic [DATA_W-1:0] res_data,
    input  logic              res_fault,
    input  logic              res_redirect,
    input  logic              retire,
    input  logic              flush,
    input  tag_t              head,
    output rob_entry_t        head_entry
);
    rob_entry_t slot_w [ROB_DEPTH];

    for (genvar g = 0; g < ROB_DEPTH; g++) begin : g_slot
        rob_entry_t slot_q;
        logic       take_alloc;
        logic       take_res;

        assign take_alloc = alloc_fire && (tail == tag_t'(g));
        assign take_res   = res_valid && (res_tag == tag_t'(g)) && slot_q.busy;

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (flush) begin
                slot_q.busy <= 1'b0;
                slot_q.done <= 1'b0;
            end else if (retire && (head == tag_t'(g))) begin
                slot_q.busy <= 1'b0;
                slot_q.done <= 1'b0;
            end else if (take_alloc) begin
                slot_q.busy     <= 1'b1;
                slot_q.done     <= 1'b0;
                slot_q.fault    <= 1'b0;
                slot_q.redirect <= 1'b0;
                slot_q.wr_en    <= alloc_wr_en;
                slot_q.dest     <= alloc_dest;
                slot_q.value    <= '0;
            end else if (take_res) begin
                slot_q.done     <= 1'b1;
                slot_q.fault    <= res_fault;
                slot_q.redirect <= res_redirect;
                slot_q.value    <= res_data;
            end
        end

        assign slot_w[g] = slot_q;

        // R9
        stale_wr_chk: assert property (@(posedge clk) disable iff (rst)
            (res_valid && res_tag == tag_t'(g) && !slot_q.busy && !take_alloc)
            |=> !slot_q.busy && !slot_q.done);
    end

    assign head_entry = slot_w[head];
endmodule

// File: rtl/rob_commit_sel.sv
module rob_commit_sel
    import rob_pkg::*;
(
    input  rob_entry_t        head_entry,
    output logic              retire,
    output logic              flush,
    output flush_cause_e      cause,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_reg,
    output logic [DATA_W-1:0] wr_data
);
    always_comb begin
        retire  = head_entry.busy && head_entry.done;
        flush   = retire && (head_entry.fault || head_entry.redirect);
        wr_en   = retire && head_entry.wr_en && !head_entry.fault;
        wr_reg  = head_entry.dest;
        wr_data = head_entry.value;
        if (!flush)                cause = CAUSE_NONE;
        else if (head_entry.fault) cause = CAUSE_EXC;
        else                       cause = CAUSE_MISPRED;
    end
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
    import rob_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_req,
    input  logic              alloc_wr_en,
    input  logic [REG_W-1:0]  alloc_dest,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    input  logic              res_fault,
    input  logic              res_redirect,
    output logic              commit_we,
    output logic [REG_W-1:0]  commit_reg,
    output logic [DATA_W-1:0] commit_data,
    output logic              flush_o,
    output logic [1:0]        flush_cause
);
    tag_t         head, tail;
    logic         full, retire, alloc_fire;
    rob_entry_t   head_entry;
    flush_cause_e cause;

    assign alloc_ready = !full && !flush_o;
    assign alloc_fire  = alloc_req && alloc_ready;
    assign alloc_tag   = tail;
    assign flush_cause = cause;

    rob_ptr_ctrl u_ptr (
        .clk(clk), .rst(rst), .alloc_fire(alloc_fire), .retire(retire),
        .flush(flush_o), .head(head), .tail(tail), .full(full)
    );

    rob_entry_array u_arr (
        .clk(clk), .rst(rst), .alloc_fire(alloc_fire), .tail(tail),
        .alloc_wr_en(alloc_wr_en), .alloc_dest(alloc_dest),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .res_fault(res_fault), .res_redirect(res_redirect),
        .retire(retire), .flush(flush_o), .head(head), .head_entry(head_entry)
    );

    rob_commit_sel u_sel (
        .head_entry(head_entry), .retire(retire), .flush(flush_o), .cause(cause),
        .wr_en(commit_we), .wr_reg(commit_reg), .wr_data(commit_data)
    );

    // R2
    tag_step_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_fire |=> alloc_tag == tag_next($past(alloc_tag)));

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!alloc_ready && !flush_o) |=> $stable(alloc_tag));

    // R7
    fault_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_o && flush_cause == 2'd1) |-> !commit_we);

    // R7
    flush_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        flush_o |=> !flush_o && !commit_we);
endmodule

// File: tb/reorder_buffer_tb_top.sv
`timescale 1ns/1ps
module reorder_buffer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc_req = 0, alloc_wr_en = 0;
    logic [4:0]  alloc_dest = '0;
    logic        alloc_ready;
    logic [2:0]  alloc_tag;
    logic        res_valid = 0, res_fault = 0, res_redirect = 0;
    logic [2:0]  res_tag = '0;
    logic [31:0] res_data = '0;
    logic        commit_we, flush_o;
    logic [4:0]  commit_reg;
    logic [31:0] commit_data;
    logic [1:0]  flush_cause;

    always #2 clk = ~clk;

    reorder_buffer dut_i (.*);

    typedef struct {
        logic        is_flush;
        logic [1:0]  cause;
        logic        we;
        logic [4:0]  rg;
        logic [31:0] val;
        string       req;
    } ev_t;

    ev_t  expq[$];
    int   n_chk = 0, n_fail = 0;
    logic [2:0] exp_tag = '0;
    bit   finished = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_commit(input logic [4:0] rg, input logic [31:0] v, input string req);
        ev_t e;
        e.is_flush = 0; e.cause = 2'd0; e.we = 1; e.rg = rg; e.val = v; e.req = req;
        expq.push_back(e);
    endtask

    task automatic expect_flush(input logic [1:0] c, input logic we, input logic [4:0] rg,
                                input logic [31:0] v, input string req);
        ev_t e;
        e.is_flush = 1; e.cause = c; e.we = we; e.rg = rg; e.val = v; e.req = req;
        expq.push_back(e);
    endtask

    // monitor: outputs depend only on state, stable at the falling edge
    always @(negedge clk) begin
        if (!rst && (commit_we || flush_o)) begin
            if (expq.size() == 0) begin
                check(0, "R3 unexpected event", {26'd0, commit_reg, flush_o}, 32'd0);
            end else begin
                ev_t e;
                e = expq.pop_front();
                check(flush_o == e.is_flush, {e.req, " flush"}, 32'(flush_o), 32'(e.is_flush));
                check(flush_cause == e.cause, {e.req, " cause"}, 32'(flush_cause), 32'(e.cause));
                check(commit_we == e.we, {e.req, " we"}, 32'(commit_we), 32'(e.we));
                if (e.we) begin
                    check(commit_reg == e.rg, {e.req, " reg"}, 32'(commit_reg), 32'(e.rg));
                    check(commit_data == e.val, {e.req, " data"}, commit_data, e.val);
                end
            end
        end
    end

    task automatic cycle();
        @(posedge clk); #1;
        alloc_req = 0; res_valid = 0; res_fault = 0; res_redirect = 0;
    endtask

    task automatic do_alloc(input logic [4:0] rg, input logic we, input string req);
        check(alloc_ready === 1'b1, {req, " ready"}, 32'(alloc_ready), 32'd1);
        check(alloc_tag === exp_tag, {req, " tag"}, 32'(alloc_tag), 32'(exp_tag));
        alloc_req = 1; alloc_dest = rg; alloc_wr_en = we;
        exp_tag = exp_tag + 3'd1;
    endtask

    task automatic do_res(input logic [2:0] t, input logic [31:0] v, input logic f, input logic m);
        res_valid = 1; res_tag = t; res_data = v; res_fault = f; res_redirect = m;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        check(alloc_ready === 1'b1, "R1 ready", 32'(alloc_ready), 32'd1);
        check(alloc_tag === 3'd0, "R1 tag", 32'(alloc_tag), 32'd0);
        check(commit_we === 1'b0 && flush_o === 1'b0, "R1 idle", 32'(commit_we), 32'd0);

        // R3 out-of-order completion, in-order commit (tags 0..3)
        for (int i = 0; i < 4; i++) begin
            do_alloc(5'(i + 1), 1, "R2 seq");
            expect_commit(5'(i + 1), 32'hA000 + i, "R3 order");
            cycle();
        end
        do_res(3'd2, 32'hA002, 0, 0); cycle();
        do_res(3'd0, 32'hA000, 0, 0); cycle();
        do_res(3'd3, 32'hA003, 0, 0); cycle();
        do_res(3'd1, 32'hA001, 0, 0); cycle();
        idle(6);

        // R4 non-writing instruction (tag 4) gives no register write
        do_alloc(5'd7, 0, "R4 alloc"); cycle();
        do_res(3'd4, 32'hDEAD, 0, 0); cycle();
        idle(3);

        // R5 fill all 8 slots (tags 5..4)
        for (int i = 0; i < 8; i++) begin
            do_alloc(5'(i + 10), 1, "R5 fill");
            cycle();
        end
        check(alloc_ready === 1'b0, "R5 full ready", 32'(alloc_ready), 32'd0);
        alloc_req = 1; alloc_dest = 5'd31; alloc_wr_en = 1; cycle();
        check(alloc_tag === exp_tag, "R5 tag held", 32'(alloc_tag), 32'(exp_tag));
        for (int i = 0; i < 8; i++) expect_commit(5'(i + 10), 32'hB000 + i, "R5 drain");
        for (int i = 7; i >= 0; i--) begin
            do_res(3'(5 + i), 32'hB000 + i, 0, 0); cycle();
        end
        idle(10);

        // R6 allocate while retiring (tag 5 retires as tag 6 allocates)
        do_alloc(5'd9, 1, "R6 alloc"); expect_commit(5'd9, 32'hC005, "R6 commit"); cycle();
        do_res(3'd5, 32'hC005, 0, 0); cycle();
        do_alloc(5'd8, 1, "R6 same cycle"); cycle();
        do_alloc(5'd6, 1, "R6 next"); cycle();
        expect_commit(5'd8, 32'hC006, "R6 commit");
        expect_commit(5'd6, 32'hC007, "R6 commit");
        do_res(3'd7, 32'hC007, 0, 0); cycle();
        do_res(3'd6, 32'hC006, 0, 0); cycle();
        idle(4);

        // R7 exception at tag 1, tag 2 discarded
        do_alloc(5'd10, 1, "R7 alloc"); cycle();
        do_alloc(5'd11, 1, "R7 alloc"); cycle();
        do_alloc(5'd12, 1, "R7 alloc"); cycle();
        expect_commit(5'd10, 32'hD000, "R7 older");
        expect_flush(2'd1, 0, 5'd0, 32'd0, "R7 exc");
        do_res(3'd2, 32'hD002, 0, 0); cycle();
        do_res(3'd1, 32'hD001, 1, 0); cycle();
        do_res(3'd0, 32'hD000, 0, 0); cycle();
        idle(4);
        exp_tag = 3'd2;
        check(alloc_tag === 3'd2, "R7 restart tag", 32'(alloc_tag), 32'd2);
        // R9 stale write to the emptied slot 2 is ignored
        do_res(3'd2, 32'hEEEE, 0, 0); cycle();
        do_alloc(5'd13, 1, "R9 alloc"); cycle();
        idle(3);
        expect_commit(5'd13, 32'hD102, "R9 own result");
        do_res(3'd2, 32'hD102, 0, 0); cycle();
        idle(3);

        // R8 mispredicted branch at tag 3 writes link, tag 4 discarded
        do_alloc(5'd1, 1, "R8 alloc"); cycle();
        do_alloc(5'd2, 1, "R8 alloc"); cycle();
        expect_flush(2'd2, 1, 5'd1, 32'h55, "R8 mispred");
        do_res(3'd4, 32'h66, 0, 0); cycle();
        do_res(3'd3, 32'h55, 0, 1); cycle();
        idle(4);
        exp_tag = 3'd4;
        check(alloc_tag === 3'd4, "R8 restart tag", 32'(alloc_tag), 32'd4);

        // R10 both flags: exception wins
        do_alloc(5'd3, 1, "R10 alloc"); cycle();
        expect_flush(2'd1, 0, 5'd0, 32'd0, "R10 both");
        do_res(3'd4, 32'h77, 1, 1); cycle();
        idle(4);
        check(alloc_tag === 3'd5, "R10 restart tag", 32'(alloc_tag), 32'd5);

        check(expq.size() == 0, "R3 all expected events seen", 32'(expq.size()), 32'd0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual %0h expected %0h", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule